// File: doc/BRIEF.md
# PAM4 Eye Threshold Adaptation Controller

This controller runs in the background and places the upper and lower data-slicer thresholds of a four-level receiver. It aims for the centre of the top eye and the centre of the bottom eye. The middle slicer stays at zero and is outside its scope. A single extra comparator, the error slicer, has a threshold that the controller moves. Each cycle with `valid_i` high delivers one deserialized word. The word holds, for every symbol of every receiver slice, three bits: the upper-slicer decision, the lower-slicer decision and the error-slicer decision.

The controller first acquires coarse positions from symbol statistics. It assumes the four levels are equally likely, and it assumes nothing about their spacing. It then runs four edge searches with the error slicer. Each search starts at a data threshold and moves outward, one code per window, until the error decision first disagrees with that data slicer. The two edges found around each data threshold set its new value, their floor midpoint. After that the controller repeats the four searches for as long as it runs. Threshold codes are signed, limited to ±63, and leave the block in sign-magnitude form.

Top module: `eye_thresh_adapt`

## Requirements
- R1: Reset state. After reset, `th_hi_o` holds +1, `th_lo_o` holds 0, `th_err_o` holds 0, and `state_o` is 1.
- R2: In state 1, each window that completes raises the upper and error codes by one and lowers the lower code by one. The error code therefore stays one below the upper code.
- R3: State 1 ends on a completed window in which at most a quarter of the error decisions are 1, or when the upper code is +63. On that exit the error code is negated, the lower code becomes the new error code minus one, and `state_o` becomes 2.
- R4: In state 2, each completed window lowers the error code by one, and the lower code follows at error minus one. State 2 ends on a window in which at most a quarter of the error decisions are 0, or when the lower code is −63. The controller then enters state 3 with the error code equal to the lower code.
- R5: State 3 steps the error code up from the lower threshold and compares it with the lower decisions. State 4 starts at the upper threshold, steps down and compares with the upper decisions. A completed window with at least one disagreeing symbol ends the search and records the error code. Both data codes hold still during states 3 to 5.
- R6: State 5 starts at the upper threshold and steps up against the upper decisions. State 6 starts at the lower threshold and steps down against the lower decisions. Each ends on its first disagreement, as in R5.
- R7: At the end of state 6, the lower code becomes floor((e3+e6)/2) and the upper code becomes floor((e4+e5)/2), where eN is the code recorded in state N. The controller then returns to state 3 with the error code set to the new lower code. It never re-enters state 1 or 2 before a reset.
- R8: No code moves beyond +63 or below −63. A search whose error code sits at its limit ends and records that limit.
- R9: A search that has taken TIMEOUT steps (default 40) without a disagreement ends on its next window and records its current error code.
- R10: A window is WIN_SYMS symbols per slice, that is WIN_SYMS/DEPTH words with `valid_i` high. Words with `valid_i` low are ignored. The counts restart after every decision, and no output changes except at the end of a window.
- R11: Output encoding. Bit 6 of each code is the sign (1 means negative) and bits 5:0 are the magnitude; zero is always sent as +0. `state_o` carries the state number 1 to 6. In the input vectors, bit s is the symbol at slice s/DEPTH, position s%DEPTH. A decision bit of 1 means the sample lies above that slicer's threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Word strobe |
| hi_i | input | NSLICE*DEPTH | Upper-slicer decisions |
| lo_i | input | NSLICE*DEPTH | Lower-slicer decisions |
| err_i | input | NSLICE*DEPTH | Error-slicer decisions |
| th_hi_o | output | 7 | Upper threshold, sign-magnitude |
| th_lo_o | output | 7 | Lower threshold, sign-magnitude |
| th_err_o | output | 7 | Error threshold, sign-magnitude |
| state_o | output | 3 | Current adaptation state |

## Verification
The bench closes the loop. It slices its own synthetic four-level samples against the thresholds the controller currently drives, and it compares every output on every clock with a behavioural model. The first corner case is a stream that is always high. This drives the acquisition into both code limits and makes two searches end by timeout and two by saturation. A design that wraps codes or ignores the step limit lands on wrong midpoints there, or it never leaves state 1. The window test interleaves idle words with valid ones and checks that nothing moves one word before the window ends. Level sets with symmetric and with compressed, unequal spacing then check that each threshold settles between its own pair of level clouds. A design that mirrored one eye onto the other, or that compared the error slicer against the wrong data slicer, would place a threshold inside a cloud.

// File: rtl/eta_pkg.sv
package eta_pkg;
  localparam int unsigned CODE_W   = 7;
  localparam int          CODE_MAX = 2 ** (CODE_W - 1) - 1;

  typedef logic signed [CODE_W-1:0] code_t;

  typedef enum logic [2:0] {
    ST_ACQ_HI = 3'd1,
    ST_ACQ_LO = 3'd2,
    ST_LO_UP  = 3'd3,
    ST_HI_DN  = 3'd4,
    ST_HI_UP  = 3'd5,
    ST_LO_DN  = 3'd6
  } st_e;

  function automatic code_t step_sat(code_t v, logic up);
    code_t lim;
    lim = up ? code_t'(CODE_MAX) : code_t'(-CODE_MAX);
    if (v == lim) return v;
    return up ? code_t'(v + code_t'(1)) : code_t'(v - code_t'(1));
  endfunction
endpackage

// File: rtl/eta_tally.sv
module eta_tally #(
  parameter int NSYM  = 8,
  parameter int WORDS = 128,
  localparam int TOT   = NSYM * WORDS,
  localparam int CNT_W = $clog2(TOT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [NSYM-1:0]  err_i,
  input  logic [NSYM-1:0]  ref_i,
  output logic             done_o,
  output logic [CNT_W-1:0] ones_o,
  output logic [CNT_W-1:0] mis_o
);
  localparam int WC_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int PC_W = $clog2(NSYM + 1);

  logic [NSYM-1:0]  diff;
  logic [PC_W-1:0]  pop_err, pop_mis;
  logic [WC_W-1:0]  wcnt_q;
  logic [CNT_W-1:0] acc_err_q, acc_mis_q;

  for (genvar g = 0; g < NSYM; g++) begin : g_diff
    assign diff[g] = err_i[g] ^ ref_i[g];
  end

  always_comb begin
    pop_err = '0;
    pop_mis = '0;
    for (int i = 0; i < NSYM; i++) begin
      pop_err = pop_err + PC_W'(err_i[i]);
      pop_mis = pop_mis + PC_W'(diff[i]);
    end
  end

  assign done_o = valid_i && (wcnt_q == WC_W'(WORDS - 1));
  assign ones_o = acc_err_q + CNT_W'(pop_err);
  assign mis_o  = acc_mis_q + CNT_W'(pop_mis);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q    <= '0;
      acc_err_q <= '0;
      acc_mis_q <= '0;
    end else if (valid_i) begin
      if (done_o) begin
        wcnt_q    <= '0;
        acc_err_q <= '0;
        acc_mis_q <= '0;
      end else begin
        wcnt_q    <= wcnt_q + WC_W'(1);
        acc_err_q <= ones_o;
        acc_mis_q <= mis_o;
      end
    end
  end
endmodule

// File: rtl/eta_seq.sv
module eta_seq
  import eta_pkg::*;
#(
  parameter int TOT     = 1024,
  parameter int CNT_W   = 11,
  parameter int TIMEOUT = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [CNT_W-1:0] ones_i,
  input  logic [CNT_W-1:0] mis_i,
  output st_e              st_o,
  output code_t            top_o,
  output code_t            bot_o,
  output code_t            err_o,
  output logic             ref_hi_o
);
  localparam int    STEP_W = $clog2(TIMEOUT + 1);
  localparam code_t C_MAX  = code_t'(CODE_MAX);
  localparam code_t C_MIN  = code_t'(-CODE_MAX);

  st_e   st_q;
  code_t top_q, bot_q, err_q, e3_q, e4_q, e5_q;
  logic [STEP_W-1:0] steps_q;

  logic  up, at_lim, tmo, fin, q_ones, q_zeros;
  code_t err_up, err_dn, err_nxt, neg_err, mid_lo, mid_hi;
  logic signed [CODE_W:0] sum_lo, sum_hi;

  assign up      = (st_q == ST_LO_UP) || (st_q == ST_HI_UP);
  assign at_lim  = up ? (err_q == C_MAX) : (err_q == C_MIN);
  assign tmo     = (steps_q == STEP_W'(TIMEOUT));
  assign fin     = (mis_i != '0) || at_lim || tmo;
  assign q_ones  = (int'(ones_i) * 4) <= TOT;
  assign q_zeros = ((TOT - int'(ones_i)) * 4) <= TOT;
  assign err_up  = step_sat(err_q, 1'b1);
  assign err_dn  = step_sat(err_q, 1'b0);
  assign err_nxt = up ? err_up : err_dn;
  assign neg_err = -err_q;

  // midpoints of the two edge pairs, floor division
  assign sum_lo = {e3_q[CODE_W-1], e3_q} + {err_q[CODE_W-1], err_q};
  assign sum_hi = {e4_q[CODE_W-1], e4_q} + {e5_q[CODE_W-1], e5_q};
  assign mid_lo = code_t'(sum_lo >>> 1);
  assign mid_hi = code_t'(sum_hi >>> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_ACQ_HI;
      top_q   <= code_t'(1);
      bot_q   <= '0;
      err_q   <= '0;
      e3_q    <= '0;
      e4_q    <= '0;
      e5_q    <= '0;
      steps_q <= '0;
    end else if (done_i) begin
      unique case (st_q)
        ST_ACQ_HI: begin
          if (q_ones || top_q == C_MAX) begin
            st_q  <= ST_ACQ_LO;
            err_q <= neg_err;
            bot_q <= step_sat(neg_err, 1'b0);
          end else begin
            top_q <= step_sat(top_q, 1'b1);
            err_q <= err_up;
            bot_q <= step_sat(bot_q, 1'b0);
          end
        end
        ST_ACQ_LO: begin
          if (q_zeros || bot_q == C_MIN) begin
            st_q    <= ST_LO_UP;
            err_q   <= bot_q;
            steps_q <= '0;
          end else begin
            err_q <= err_dn;
            bot_q <= step_sat(err_dn, 1'b0);
          end
        end
        default: begin
          if (fin) begin
            steps_q <= '0;
            unique case (st_q)
              ST_LO_UP: begin e3_q <= err_q; st_q <= ST_HI_DN; err_q <= top_q; end
              ST_HI_DN: begin e4_q <= err_q; st_q <= ST_HI_UP; err_q <= top_q; end
              ST_HI_UP: begin e5_q <= err_q; st_q <= ST_LO_DN; err_q <= bot_q; end
              default: begin
                bot_q <= mid_lo;
                top_q <= mid_hi;
                err_q <= mid_lo;
                st_q  <= ST_LO_UP;
              end
            endcase
          end else begin
            err_q   <= err_nxt;
            steps_q <= steps_q + STEP_W'(1);
          end
        end
      endcase
    end
  end

  assign st_o     = st_q;
  assign top_o    = top_q;
  assign bot_o    = bot_q;
  assign err_o    = err_q;
  assign ref_hi_o = (st_q == ST_HI_DN) || (st_q == ST_HI_UP);
endmodule

// File: rtl/eta_smag.sv
module eta_smag #(
  parameter int W = 7
) (
  input  logic signed [W-1:0] code_i,
  output logic        [W-1:0] smag_o
);
  logic signed [W-1:0] neg;
  assign neg    = -code_i;
  assign smag_o = code_i[W-1] ? {1'b1, neg[W-2:0]} : {1'b0, code_i[W-2:0]};
endmodule

// File: rtl/eye_thresh_adapt.sv
module eye_thresh_adapt
  import eta_pkg::*;
#(
  parameter int NSLICE   = 4,
  parameter int DEPTH    = 2,
  parameter int WIN_SYMS = 256,
  parameter int TIMEOUT  = 40,
  localparam int NSYM    = NSLICE * DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [NSYM-1:0]   hi_i,
  input  logic [NSYM-1:0]   lo_i,
  input  logic [NSYM-1:0]   err_i,
  output logic [CODE_W-1:0] th_hi_o,
  output logic [CODE_W-1:0] th_lo_o,
  output logic [CODE_W-1:0] th_err_o,
  output logic [2:0]        state_o
);
  localparam int WORDS = WIN_SYMS / DEPTH;
  localparam int TOT   = NSYM * WORDS;
  localparam int CNT_W = $clog2(TOT + 1);

  logic             win_done, ref_hi;
  logic [NSYM-1:0]  ref_vec;
  logic [CNT_W-1:0] ones, mis;
  st_e              st;
  code_t            code_a [3];
  logic [CODE_W-1:0] smag_a [3];

  assign ref_vec = ref_hi ? hi_i : lo_i;

  eta_tally #(.NSYM(NSYM), .WORDS(WORDS)) u_tally (
    .clk_i, .rst_ni, .valid_i,
    .err_i, .ref_i(ref_vec),
    .done_o(win_done), .ones_o(ones), .mis_o(mis)
  );

  eta_seq #(.TOT(TOT), .CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_seq (
    .clk_i, .rst_ni,
    .done_i(win_done), .ones_i(ones), .mis_i(mis),
    .st_o(st), .top_o(code_a[0]), .bot_o(code_a[1]), .err_o(code_a[2]),
    .ref_hi_o(ref_hi)
  );

  for (genvar g = 0; g < 3; g++) begin : g_enc
    eta_smag #(.W(CODE_W)) u_enc (.code_i(code_a[g]), .smag_o(smag_a[g]));
  end

  assign th_hi_o  = smag_a[0];
  assign th_lo_o  = smag_a[1];
  assign th_err_o = smag_a[2];
  assign state_o  = st;
endmodule

// File: rtl/eye_thresh_adapt_chk.sv
module eye_thresh_adapt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       win_done_i,
  input logic [6:0] th_hi_i,
  input logic [6:0] th_lo_i,
  input logic [6:0] th_err_i,
  input logic [2:0] state_i
);
  function automatic int dec(logic [6:0] c);
    return c[6] ? -int'(c[5:0]) : int'(c[5:0]);
  endfunction

  // R10
  win_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_done_i |=> $stable(th_hi_i) && $stable(th_lo_i) && $stable(th_err_i) && $stable(state_i));

  // R11
  no_neg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    th_hi_i != 7'h40 && th_lo_i != 7'h40 && th_err_i != 7'h40 && state_i >= 3'd1 && state_i <= 3'd6);

  // R2
  acq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done_i && state_i == 3'd1) |=> state_i == 3'd2 ||
      (dec(th_hi_i) == dec($past(th_hi_i)) + 1 && dec(th_err_i) == dec(th_hi_i) - 1 &&
       dec(th_lo_i) == dec($past(th_lo_i)) - 1));

  // R4
  lo_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd2 |-> dec(th_lo_i) == dec(th_err_i) - 1);

  // R5
  data_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done_i && state_i >= 3'd3 && state_i <= 3'd5) |=> $stable(th_hi_i) && $stable(th_lo_i));

  // R7
  loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i >= 3'd3 |=> state_i >= 3'd3);
endmodule

bind eye_thresh_adapt eye_thresh_adapt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .win_done_i(win_done),
  .th_hi_i(th_hi_o), .th_lo_i(th_lo_o), .th_err_i(th_err_o), .state_i(state_o)
);

// File: tb/sim_eye_thresh_adapt.sv
`timescale 1ns/1ps
module sim_eye_thresh_adapt;
  localparam int NSLICE = 4, DEPTH = 2, WIN_SYMS = 256, TIMEOUT = 40;
  localparam int NSYM = NSLICE * DEPTH, WORDS = WIN_SYMS / DEPTH, TOT = NSYM * WORDS;
  localparam int WD_CYC = 150000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [NSYM-1:0] hi_v = '0, lo_v = '0, er_v = '0;
  logic [6:0] th_hi, th_lo, th_err;
  logic [2:0] st;

  eye_thresh_adapt #(.NSLICE(NSLICE), .DEPTH(DEPTH), .WIN_SYMS(WIN_SYMS), .TIMEOUT(TIMEOUT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .hi_i(hi_v), .lo_i(lo_v), .err_i(er_v),
    .th_hi_o(th_hi), .th_lo_o(th_lo), .th_err_o(th_err), .state_o(st)
  );

  int n_chk = 0, n_fail = 0;
  int m_st, m_top, m_bot, m_err, m_wc, m_ones, m_mis, m_steps, m_e3, m_e4, m_e5;
  int lv[4];
  int noise = 0, mode = 0, vp = 100;
  bit done_run = 0;

  function automatic int dec(logic [6:0] c);
    return c[6] ? -int'(c[5:0]) : int'(c[5:0]);
  endfunction

  function automatic int sat(int v);
    return (v > 63) ? 63 : (v < -63) ? -63 : v;
  endfunction

  function automatic string tag_of(int s);
    case (s)
      1: return "R2";
      2: return "R4";
      3, 4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 1; m_top = 1; m_bot = 0; m_err = 0;
    m_wc = 0; m_ones = 0; m_mis = 0; m_steps = 0;
    m_e3 = 0; m_e4 = 0; m_e5 = 0;
  endtask

  task automatic model_step(input bit v, input logic [NSYM-1:0] h, input logic [NSYM-1:0] l,
                            input logic [NSYM-1:0] e);
    bit up, fin;
    if (!v) return;
    for (int s = 0; s < NSYM; s++) begin
      m_ones += int'(e[s]);
      m_mis  += int'(e[s] ^ ((m_st == 4 || m_st == 5) ? h[s] : l[s]));
    end
    m_wc++;
    if (m_wc < WORDS) return;
    case (m_st)
      1: if (m_ones * 4 <= TOT || m_top == 63) begin
           m_st = 2; m_err = -m_err; m_bot = sat(m_err - 1);
         end else begin
           m_top = sat(m_top + 1); m_err = sat(m_err + 1); m_bot = sat(m_bot - 1);
         end
      2: if ((TOT - m_ones) * 4 <= TOT || m_bot == -63) begin
           m_st = 3; m_err = m_bot; m_steps = 0;
         end else begin
           m_err = sat(m_err - 1); m_bot = sat(m_err - 1);
         end
      default: begin
        up  = (m_st == 3 || m_st == 5);
        fin = (m_mis > 0) || (up ? m_err == 63 : m_err == -63) || (m_steps == TIMEOUT);
        if (fin) begin
          m_steps = 0;
          case (m_st)
            3: begin m_e3 = m_err; m_st = 4; m_err = m_top; end
            4: begin m_e4 = m_err; m_st = 5; m_err = m_top; end
            5: begin m_e5 = m_err; m_st = 6; m_err = m_bot; end
            default: begin
              m_bot = $floor(real'(m_e3 + m_err) / 2.0);
              m_top = $floor(real'(m_e4 + m_e5) / 2.0);
              m_err = m_bot; m_st = 3;
            end
          endcase
        end else begin
          m_err = sat(m_err + (up ? 1 : -1));
          m_steps++;
        end
      end
    endcase
    m_wc = 0; m_ones = 0; m_mis = 0;
  endtask

  function automatic int gen_x();
    if (mode == 0) return 100;
    return lv[$urandom_range(3)] + int'($urandom_range(2 * noise)) - noise;
  endfunction

  task automatic cycle();
    logic [NSYM-1:0] h, l, e;
    bit v;
    @(negedge clk);
    if (rst_n) begin
      check(dec(th_hi) == m_top, tag_of(m_st), "th_hi", dec(th_hi), m_top);
      check(dec(th_lo) == m_bot, tag_of(m_st), "th_lo", dec(th_lo), m_bot);
      check(dec(th_err) == m_err, tag_of(m_st), "th_err", dec(th_err), m_err);
      check(int'(st) == m_st, "R7", "state", int'(st), m_st);
    end
    v = (int'($urandom_range(99)) < vp);
    for (int s = 0; s < NSYM; s++) begin
      int x;
      x = gen_x();
      h[s] = (x > m_top);
      l[s] = (x > m_bot);
      e[s] = (x > m_err);
    end
    valid = v; hi_v = h; lo_v = l; er_v = e;
    model_step(v, h, l, e);
  endtask

  task automatic run_until_st(input int target);
    int k = 0;
    while (m_st != target && k < 40000) begin cycle(); k++; end
    check(m_st == target, "R7", "state reached", m_st, target);
    cycle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done_run) begin
      check(1'b0, "R10", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    // saturating stream
    do_reset();
    check(dec(th_hi) == 1, "R1", "reset th_hi", dec(th_hi), 1);
    check(th_lo == 7'h00, "R1", "reset th_lo raw", int'(th_lo), 0);
    check(dec(th_err) == 0, "R1", "reset th_err", dec(th_err), 0);
    check(st == 3'd1, "R1", "reset state", int'(st), 1);
    mode = 0; vp = 50;
    while (m_wc != WORDS - 1) cycle();
    vp = 0;
    cycle();
    check(dec(th_hi) == 1, "R10", "hi before window end", dec(th_hi), 1);
    vp = 100;
    cycle();
    vp = 0;
    cycle();
    check(dec(th_hi) == 2, "R2", "hi after first window", dec(th_hi), 2);
    check(dec(th_err) == 1, "R2", "err after first window", dec(th_err), 1);
    check(dec(th_lo) == -1, "R2", "lo after first window", dec(th_lo), -1);
    vp = 100;
    run_until_st(2);
    check(dec(th_hi) == 63, "R8", "hi saturated", dec(th_hi), 63);
    check(dec(th_err) == -62, "R3", "err negated", dec(th_err), -62);
    check(th_lo == 7'b1111111, "R11", "lo raw -63", int'(th_lo), 127);
    run_until_st(4);
    check(dec(th_err) == dec(th_hi), "R5", "state 4 start", dec(th_err), dec(th_hi));
    run_until_st(3);
    check(dec(th_lo) == -43, "R9", "lo after timeout pass", dec(th_lo), -43);
    check(dec(th_hi) == 43, "R9", "hi after timeout pass", dec(th_hi), 43);
    check(dec(th_err) == -43, "R7", "err restarts at lo", dec(th_err), -43);

    // symmetric levels
    do_reset();
    mode = 1; noise = 6; vp = 87;
    lv[0] = -48; lv[1] = -16; lv[2] = 16; lv[3] = 48;
    run_until_st(3);
    check(dec(th_err) == dec(th_lo), "R4", "state 3 start", dec(th_err), dec(th_lo));
    run_until_st(5);
    check(dec(th_err) == dec(th_hi), "R6", "state 5 start", dec(th_err), dec(th_hi));
    run_until_st(6);
    check(dec(th_err) == dec(th_lo), "R6", "state 6 start", dec(th_err), dec(th_lo));
    run_until_st(3);
    check(dec(th_hi) >= 21 && dec(th_hi) <= 43, "R7", "hi in top eye", dec(th_hi), 32);
    check(dec(th_lo) >= -43 && dec(th_lo) <= -21, "R7", "lo in bottom eye", dec(th_lo), -32);
    repeat (3000) cycle();
    check(st >= 3'd3, "R7", "stays in tracking", int'(st), 3);

    // compressed, unequal spacing
    do_reset();
    lv[0] = -44; lv[1] = -14; lv[2] = 18; lv[3] = 40;
    run_until_st(6);
    run_until_st(3);
    run_until_st(6);
    run_until_st(3);
    check(dec(th_hi) >= 23 && dec(th_hi) <= 35, "R7", "hi in narrow top eye", dec(th_hi), 28);
    check(dec(th_lo) >= -38 && dec(th_lo) <= -20, "R7", "lo in bottom eye", dec(th_lo), -30);

    done_run = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule